// File: doc/BRIEF.md
# Timestamp Counter with Sync Output

This block keeps a free-running time count on its own reference clock. Software configures it through a small register write port: a control word, a correction interval and a compare value split across two halves. The count can run at half width, where the upper half stays zero, or at full width. A periodic correction either adds one extra count or drops one count at a programmable interval, so the count can be trimmed faster or slower than the reference clock.

Three outputs are derived from the count. A sync output follows one upper counter bit, selected by a 4-bit code, one cycle late. A compare output fires when the count equals the compare value. It has a programmable active level and can either pulse or toggle. A receive strobe captures a timestamp with a valid flag. In a test mode that timestamp is the index of the packet (1, 2, 3, ...) rather than the time.

Register map (address on `wr_addr`): 0 control, 1 correction interval, 2 compare lower half, 3 compare upper half. The count is gated by a two-state sequencer (TB_HELD, TB_RUN). TB_HELD moves to TB_RUN when the enable bit is set, and TB_RUN moves back to TB_HELD when it is cleared. Correction is timed by a second sequencer (CR_OFF, CR_WAIT): it enters CR_WAIT while running with a nonzero interval, and returns to CR_OFF when either condition drops. The compare level is held in a third sequencer (CMP_IDLE, CMP_ACTIVE), which moves on a match as set by the toggle bit and returns to CMP_IDLE while held.

Top module: `tsync_timebase`

## Requirements
- R1: After reset `time_now` is 0, `sync_out` is 0, `cmp_out` is 0 and `rx_stamp_vld` is 0. The control word resets with only bit 5 (compare polarity) set, the interval resets to 0, and the compare value resets to all ones.
- R2: Control bit 0 is the enable. While it is clear, the count stays 0 and the sync, compare, sequence and stamp logic stay in reset, so a receive strobe yields nothing. After the write that sets it, `time_now` reads 1 following the second clock edge after that write, then rises by 1 per cycle.
- R3: Control bit 1 selects full width. While it is clear, the upper half of `time_now` is 0 and the lower half wraps modulo 2^(TS_W/2). While it is set, the lower half carries into the upper half.
- R4: Control bits 11:8 form the sync code. Code 0 holds `sync_out` at 0. Code n (1 to 15) makes `sync_out` equal to counter bit SYNC_BASE+n-1, one cycle after that bit. With the default SYNC_BASE of 17, code 1 selects bit 17 and code 15 selects bit 31.
- R5: With a nonzero interval N (address 1) and control bit 7 clear, every N-th running cycle the count advances by 2 instead of 1, giving N+1 counts per N cycles.
- R6: With a nonzero interval N and control bit 7 set, every N-th running cycle the count holds, giving N-1 counts per N cycles.
- R7: An interval of 0 disables correction, so the count advances by exactly 1 per cycle.
- R8: With control bit 6 clear (pulse mode), a cycle in which `time_now` equals the compare value (address 2 lower half, address 3 upper half) makes `cmp_out` active for exactly the following cycle.
- R9: With control bit 6 set (toggle mode), each match cycle inverts the level of `cmp_out` in the following cycle, and the level holds between matches.
- R10: Control bit 5 sets the compare polarity. When it is 1, `cmp_out` is active high and idles low. When it is 0, `cmp_out` is active low and idles high.
- R11: A strobe on `rx_pkt` while enabled and with control bit 3 set raises `rx_stamp_vld` for the next cycle. In that cycle `rx_stamp` equals the `time_now` of the strobe cycle. In any other case no valid is produced.
- R12: Control bit 4 set suppresses every receive stamp, even with bit 3 set.
- R13: With control bit 2 set, stamps carry packet indices 1, 2, 3, ... counted over every strobe while enabled. Clearing and setting the bit again restarts the index at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| rx_pkt | input | 1 | Receive packet strobe |
| time_now | output | TS_W | Current count |
| sync_out | output | 1 | Selected counter bit, registered |
| cmp_out | output | 1 | Compare output at programmed polarity |
| rx_stamp | output | TS_W | Captured receive timestamp or index |
| rx_stamp_vld | output | 1 | One-cycle valid for `rx_stamp` |

## Verification
The checker watches the following on every cycle:
- The count returns to zero after a held cycle, and the upper half stays zero after a half-width cycle.
- The lower half never steps by more than 2 between running cycles.
- The sync output is quiet under code 0 or while held.
- A valid stamp always follows an accepted strobe.
- The compare output idles at the level opposite its polarity while held.

Only the bench's scenarios can show the rest: exact correction rates over a window, wrap and carry at the half boundary, the single-cycle pulse versus toggle level at a chosen compare value, the captured stamp values, and the packet index restarting.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

    localparam int REG_W    = 32;
    localparam int SEL_W    = 4;
    localparam int NUM_TAPS = 1 << SEL_W;

    localparam logic [1:0] ADDR_CTL    = 2'd0;
    localparam logic [1:0] ADDR_CORR   = 2'd1;
    localparam logic [1:0] ADDR_CMP_LO = 2'd2;
    localparam logic [1:0] ADDR_CMP_HI = 2'd3;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic [SEL_W-1:0] sync_sel; // 11:8
        logic             slow;     // 7
        logic             tog;      // 6
        logic             pol;      // 5
        logic             mute;     // 4
        logic             rx_en;    // 3
        logic             seq;      // 2
        logic             wide;     // 1
        logic             run;      // 0
    } tsync_ctl_t;

    localparam int CTL_W = $bits(tsync_ctl_t);

    localparam tsync_ctl_t CTL_RESET = '{
        sync_sel: '0, slow: 1'b0, tog: 1'b0, pol: 1'b1,
        mute: 1'b0, rx_en: 1'b0, seq: 1'b0, wide: 1'b0, run: 1'b0
    };

    typedef enum logic { TB_HELD = 1'b0, TB_RUN = 1'b1 } tb_state_t;
    typedef enum logic { CR_OFF = 1'b0, CR_WAIT = 1'b1 } cr_state_t;
    typedef enum logic { CMP_IDLE = 1'b0, CMP_ACTIVE = 1'b1 } cmp_state_t;

endpackage

// File: rtl/tsync_regs.sv
module tsync_regs
    import tsync_pkg::*;
#(
    parameter int TS_W   = 64,
    parameter int CORR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output tsync_ctl_t        ctl,
    output logic [CORR_W-1:0] corr_ivl,
    output logic [TS_W-1:0]   cmp_val
);
    localparam int HALF = TS_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl      <= CTL_RESET;
            corr_ivl <= '0;
            cmp_val  <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTL:    ctl <= tsync_ctl_t'(wr_data[CTL_W-1:0]);
                ADDR_CORR:   corr_ivl <= wr_data[CORR_W-1:0];
                ADDR_CMP_LO: cmp_val[HALF-1:0] <= wr_data[HALF-1:0];
                default:     cmp_val[TS_W-1:HALF] <= wr_data[HALF-1:0];
            endcase
        end
    end

endmodule

// File: rtl/tsync_count.sv
module tsync_count
    import tsync_pkg::*;
#(
    parameter int TS_W   = 64,
    parameter int CORR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wide,
    input  logic              slow,
    input  logic [CORR_W-1:0] corr_ivl,
    output logic [TS_W-1:0]   time_now,
    output logic              running
);
    localparam int HALF = TS_W / 2;

    tb_state_t         tb_q, tb_d;
    cr_state_t         cr_q, cr_d;
    logic [CORR_W-1:0] corr_cnt;
    logic              ivl_set;
    logic              corr_tick;
    logic [1:0]        step;
    logic [TS_W-1:0]   sum;
    logic [TS_W-1:0]   time_d;

    assign ivl_set = (corr_ivl != '0);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= TB_HELD;
            cr_q <= CR_OFF;
        end else begin
            tb_q <= tb_d;
            cr_q <= cr_d;
        end
    end

    // next-state logic
    always_comb begin
        tb_d = tb_q;
        unique case (tb_q)
            TB_HELD: if (run)  tb_d = TB_RUN;
            TB_RUN:  if (!run) tb_d = TB_HELD;
            default: tb_d = TB_HELD;
        endcase
        cr_d = cr_q;
        unique case (cr_q)
            CR_OFF:  if (running && ivl_set)    cr_d = CR_WAIT;
            CR_WAIT: if (!running || !ivl_set)  cr_d = CR_OFF;
            default: cr_d = CR_OFF;
        endcase
    end

    assign running   = (tb_q == TB_RUN);
    assign corr_tick = (cr_q == CR_WAIT) && ivl_set
                       && (corr_cnt >= corr_ivl - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            corr_cnt <= '0;
        else if (cr_q != CR_WAIT || corr_tick)
            corr_cnt <= '0;
        else
            corr_cnt <= corr_cnt + 1'b1;
    end

    // output process: next count
    always_comb begin
        if (!corr_tick)
            step = 2'd1;
        else if (slow)
            step = 2'd0;
        else
            step = 2'd2;
        sum = time_now + TS_W'(step);
        if (!running)
            time_d = '0;
        else if (wide)
            time_d = sum;
        else
            time_d = {{(TS_W-HALF){1'b0}}, sum[HALF-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            time_now <= '0;
        else
            time_now <= time_d;
    end

endmodule

// File: rtl/tsync_cmpsync.sv
module tsync_cmpsync
    import tsync_pkg::*;
#(
    parameter int TS_W      = 64,
    parameter int SYNC_BASE = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tog,
    input  logic             pol,
    input  logic [SEL_W-1:0] sync_sel,
    input  logic [TS_W-1:0]  time_now,
    input  logic [TS_W-1:0]  cmp_val,
    output logic             sync_out,
    output logic             cmp_out
);
    cmp_state_t          cm_q, cm_d;
    logic                hit;
    logic [NUM_TAPS-1:0] taps;
    logic                sync_q;

    assign hit = running && (time_now == cmp_val);

    // tap vector: code 0 is a constant low, codes 1..15 are counter bits
    assign taps[0] = 1'b0;
    for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
        assign taps[k] = time_now[SYNC_BASE + k - 1];
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_q   <= CMP_IDLE;
            sync_q <= 1'b0;
        end else begin
            cm_q   <= cm_d;
            sync_q <= running ? taps[sync_sel] : 1'b0;
        end
    end

    always_comb begin
        cm_d = cm_q;
        if (!running) begin
            cm_d = CMP_IDLE;
        end else begin
            unique case (cm_q)
                CMP_IDLE:   if (hit) cm_d = CMP_ACTIVE;
                CMP_ACTIVE: begin
                    if (tog) begin
                        if (hit) cm_d = CMP_IDLE;
                    end else if (!hit) begin
                        cm_d = CMP_IDLE;
                    end
                end
                default: cm_d = CMP_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        sync_out = sync_q;
        cmp_out  = pol ? (cm_q == CMP_ACTIVE) : (cm_q != CMP_ACTIVE);
    end

endmodule

// File: rtl/tsync_rxstamp.sv
module tsync_rxstamp #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            running,
    input  logic            seq,
    input  logic            rx_en,
    input  logic            mute,
    input  logic            rx_pkt,
    input  logic [TS_W-1:0] time_now,
    output logic [TS_W-1:0] rx_stamp,
    output logic            rx_stamp_vld
);
    logic [TS_W-1:0] seq_cnt;
    logic [TS_W-1:0] seq_next;
    logic            deliver;

    assign seq_next = seq_cnt + 1'b1;
    assign deliver  = running && rx_pkt && rx_en && !mute;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_cnt <= '0;
        else if (!running || !seq)
            seq_cnt <= '0;
        else if (rx_pkt)
            seq_cnt <= seq_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_stamp     <= '0;
            rx_stamp_vld <= 1'b0;
        end else if (!running) begin
            rx_stamp     <= '0;
            rx_stamp_vld <= 1'b0;
        end else begin
            rx_stamp_vld <= deliver;
            if (deliver)
                rx_stamp <= seq ? seq_next : time_now;
        end
    end

endmodule

// File: rtl/tsync_timebase.sv
module tsync_timebase
    import tsync_pkg::*;
#(
    parameter int TS_W      = 64,
    parameter int CORR_W    = 32,
    parameter int SYNC_BASE = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rx_pkt,
    output logic [TS_W-1:0]  time_now,
    output logic             sync_out,
    output logic             cmp_out,
    output logic [TS_W-1:0]  rx_stamp,
    output logic             rx_stamp_vld
);
    tsync_ctl_t        ctl;
    logic [CORR_W-1:0] corr_ivl;
    logic [TS_W-1:0]   cmp_val;
    logic              running;

    tsync_regs #(.TS_W(TS_W), .CORR_W(CORR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctl      (ctl),
        .corr_ivl (corr_ivl),
        .cmp_val  (cmp_val)
    );

    tsync_count #(.TS_W(TS_W), .CORR_W(CORR_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctl.run),
        .wide     (ctl.wide),
        .slow     (ctl.slow),
        .corr_ivl (corr_ivl),
        .time_now (time_now),
        .running  (running)
    );

    tsync_cmpsync #(.TS_W(TS_W), .SYNC_BASE(SYNC_BASE)) u_cmpsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .tog      (ctl.tog),
        .pol      (ctl.pol),
        .sync_sel (ctl.sync_sel),
        .time_now (time_now),
        .cmp_val  (cmp_val),
        .sync_out (sync_out),
        .cmp_out  (cmp_out)
    );

    tsync_rxstamp #(.TS_W(TS_W)) u_rxstamp (
        .clk          (clk),
        .rst_n        (rst_n),
        .running      (running),
        .seq          (ctl.seq),
        .rx_en        (ctl.rx_en),
        .mute         (ctl.mute),
        .rx_pkt       (rx_pkt),
        .time_now     (time_now),
        .rx_stamp     (rx_stamp),
        .rx_stamp_vld (rx_stamp_vld)
    );

endmodule

// File: rtl/tsync_timebase_chk.sv
module tsync_timebase_chk #(
    parameter int TS_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            running,
    input logic            wide,
    input logic            rx_en,
    input logic            mute,
    input logic            pol,
    input logic [3:0]      sync_sel,
    input logic            rx_pkt,
    input logic [TS_W-1:0] time_now,
    input logic            sync_out,
    input logic            cmp_out,
    input logic            rx_vld
);
    localparam int HALF = TS_W / 2;

    AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> time_now == '0); // R2

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wide) |-> time_now[TS_W-1:HALF] == '0); // R3

    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_sel) == 4'd0 || !$past(running)) |-> !sync_out); // R4

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |->
        (HALF'(time_now[HALF-1:0] - $past(time_now[HALF-1:0])) <= HALF'(2))); // R5

    AST_CMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> cmp_out == !pol); // R10

    AST_RX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> $past(rx_pkt && running && rx_en && !mute)); // R11

endmodule

bind tsync_timebase tsync_timebase_chk #(.TS_W(TS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .wide     (ctl.wide),
    .rx_en    (ctl.rx_en),
    .mute     (ctl.mute),
    .pol      (ctl.pol),
    .sync_sel (ctl.sync_sel),
    .rx_pkt   (rx_pkt),
    .time_now (time_now),
    .sync_out (sync_out),
    .cmp_out  (cmp_out),
    .rx_vld   (rx_stamp_vld)
);

// File: tb/test_tsync_timebase.sv
module test_tsync_timebase;
    localparam int W  = 24;
    localparam int H  = W / 2;
    localparam int SB = 3;

    localparam logic [31:0] C_RUN  = 32'h001;
    localparam logic [31:0] C_WIDE = 32'h002;
    localparam logic [31:0] C_SEQ  = 32'h004;
    localparam logic [31:0] C_RXEN = 32'h008;
    localparam logic [31:0] C_MUTE = 32'h010;
    localparam logic [31:0] C_POL  = 32'h020;
    localparam logic [31:0] C_TOG  = 32'h040;
    localparam logic [31:0] C_SLOW = 32'h080;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [1:0]    wr_addr;
    logic [31:0]   wr_data;
    logic          rx_pkt;
    logic [W-1:0]  time_now;
    logic          sync_out;
    logic          cmp_out;
    logic [W-1:0]  rx_stamp;
    logic          rx_stamp_vld;

    int            n_chk = 0;
    int            n_fail = 0;
    int            vld_cnt = 0;
    bit            mon_on = 1'b0;
    string         cur_tag = "R11";
    logic [W-1:0]  expq[$];
    logic [W-1:0]  mon_exp;

    always #4 clk = ~clk;

    tsync_timebase #(.TS_W(W), .CORR_W(32), .SYNC_BASE(SB)) i_tsync_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rx_pkt       (rx_pkt),
        .time_now     (time_now),
        .sync_out     (sync_out),
        .cmp_out      (cmp_out),
        .rx_stamp     (rx_stamp),
        .rx_stamp_vld (rx_stamp_vld)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: one strobe, optionally pushing the expected stamp
    task automatic pkt(input bit expect_it, input bit use_idx, input logic [W-1:0] idx);
        @(negedge clk);
        rx_pkt = 1'b1;
        if (expect_it) expq.push_back(use_idx ? idx : time_now);
        @(negedge clk);
        rx_pkt = 1'b0;
    endtask

    // monitor: pops expected stamps as valids appear
    always @(negedge clk) begin
        if (mon_on && rx_stamp_vld) begin
            vld_cnt++;
            if (expq.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL %s unexpected stamp actual=%0h expected=none", cur_tag, rx_stamp);
            end else begin
                mon_exp = expq.pop_front();
                check(cur_tag, rx_stamp, mon_exp);
            end
        end
    end

    task automatic sync_chk(input logic [3:0] code, input int n, input string tag);
        int bad = 0;
        logic [W-1:0] prev;
        logic ebit;
        prev = time_now;
        repeat (n) begin
            @(negedge clk);
            ebit = (code == 4'd0) ? 1'b0 : prev[SB + int'(code) - 1];
            if (sync_out !== ebit) bad++;
            prev = time_now;
        end
        check(tag, W'(bad), '0);
    endtask

    task automatic pick_target(output logic [W-1:0] t);
        while (time_now[H-1:0] < 60 || time_now[H-1:0] > 3950) @(negedge clk);
        t = time_now + 40;
        wr(2'd3, 32'(t[W-1:H]));
        wr(2'd2, 32'(t[H-1:0]));
    endtask

    task automatic watch_cmp(input logic lvl, input int n, output int hits, output logic [W-1:0] t_first);
        hits = 0; t_first = '0;
        repeat (n) begin
            @(negedge clk);
            if (cmp_out === lvl) begin
                if (hits == 0) t_first = time_now;
                hits++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] t0, t1, tg;
        int hits, v0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rx_pkt = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        mon_on = 1'b1;
        cycles(1);
        // R1 reset state
        check("R1 time", time_now, '0);
        check("R1 sync", W'(sync_out), '0);
        check("R1 cmp idle low", W'(cmp_out), '0);
        check("R1 valid", W'(rx_stamp_vld), '0);

        // R2 held: strobe with stamps enabled but block disabled
        wr(2'd0, C_RXEN | C_POL);
        v0 = vld_cnt;
        pkt(1'b0, 1'b0, '0);
        cycles(3);
        check("R2 held time", time_now, '0);
        check("R2 held no stamp", W'(vld_cnt - v0), '0);

        // R2 enable timing and rate
        wr(2'd0, C_RUN | C_WIDE | C_POL);
        cycles(2);
        check("R2 first count", time_now, W'(1));
        cycles(10);
        check("R2 rate", time_now, W'(11));

        // R3 carry across half boundary in wide mode
        t0 = time_now;
        cycles(5000 - int'(t0));
        check("R3 wide carry", time_now, W'(5000));
        wr(2'd0, C_RUN | C_POL);
        cycles(1);
        check("R3 narrow upper zero", W'(time_now[W-1:H]), '0);
        t1 = time_now;
        cycles(1 << H);
        check("R3 narrow wrap", time_now, t1);

        // R4 sync tap codes
        wr(2'd0, C_RUN | C_WIDE | C_POL | (32'd1 << 8));
        sync_chk(4'd1, 64, "R4 code1");
        wr(2'd0, C_RUN | C_WIDE | C_POL | (32'd5 << 8));
        sync_chk(4'd5, 300, "R4 code5");
        wr(2'd0, C_RUN | C_WIDE | C_POL | (32'd15 << 8));
        sync_chk(4'd15, 40, "R4 code15");
        wr(2'd0, C_RUN | C_WIDE | C_POL);
        sync_chk(4'd0, 64, "R4 code0");

        // R5 / R6 / R7 correction
        wr(2'd1, 32'd4);
        cycles(3);
        t0 = time_now; cycles(40);
        check("R5 faster", time_now, t0 + W'(50));
        wr(2'd0, C_RUN | C_WIDE | C_POL | C_SLOW);
        cycles(2);
        t0 = time_now; cycles(40);
        check("R6 slower", time_now, t0 + W'(30));
        wr(2'd1, 32'd0);
        cycles(2);
        t0 = time_now; cycles(40);
        check("R7 off", time_now, t0 + W'(40));

        // R8 pulse mode, active high
        wr(2'd0, C_RUN | C_WIDE | C_POL);
        pick_target(tg);
        watch_cmp(1'b1, 100, hits, t1);
        check("R8 one pulse", W'(hits), W'(1));
        check("R8 pulse cycle", t1, tg + W'(1));

        // R10 active low
        wr(2'd0, C_RUN | C_WIDE);
        cycles(1);
        check("R10 idle high", W'(cmp_out), W'(1));
        pick_target(tg);
        watch_cmp(1'b0, 100, hits, t1);
        check("R10 one low pulse", W'(hits), W'(1));
        check("R10 pulse cycle", t1, tg + W'(1));

        // R9 toggle mode
        wr(2'd0, C_RUN | C_WIDE | C_POL | C_TOG);
        pick_target(tg);
        watch_cmp(1'b1, 100, hits, t1);
        check("R9 rise cycle", t1, tg + W'(1));
        check("R9 level held", W'(cmp_out), W'(1));
        pick_target(tg);
        watch_cmp(1'b0, 100, hits, t1);
        check("R9 fall cycle", t1, tg + W'(1));
        check("R9 level low", W'(cmp_out), '0);

        // R11 captured time stamps
        cur_tag = "R11";
        wr(2'd0, C_RUN | C_WIDE | C_POL | C_RXEN);
        pkt(1'b1, 1'b0, '0);
        cycles(3);
        pkt(1'b1, 1'b0, '0);
        @(negedge clk);
        rx_pkt = 1'b1; expq.push_back(time_now);
        @(negedge clk);
        expq.push_back(time_now);
        @(negedge clk);
        rx_pkt = 1'b0;
        cycles(3);
        wr(2'd0, C_RUN | C_WIDE | C_POL);
        v0 = vld_cnt;
        pkt(1'b0, 1'b0, '0);
        cycles(3);
        check("R11 disabled no stamp", W'(vld_cnt - v0), '0);

        // R12 mute
        wr(2'd0, C_RUN | C_WIDE | C_POL | C_RXEN | C_MUTE);
        v0 = vld_cnt;
        pkt(1'b0, 1'b0, '0);
        pkt(1'b0, 1'b0, '0);
        cycles(3);
        check("R12 muted no stamp", W'(vld_cnt - v0), '0);

        // R13 sequence indices and restart
        cur_tag = "R13";
        wr(2'd0, C_RUN | C_WIDE | C_POL | C_RXEN | C_SEQ);
        pkt(1'b1, 1'b1, W'(1));
        cycles(2);
        pkt(1'b1, 1'b1, W'(2));
        pkt(1'b1, 1'b1, W'(3));
        cycles(3);
        wr(2'd0, C_RUN | C_WIDE | C_POL | C_RXEN);
        wr(2'd0, C_RUN | C_WIDE | C_POL | C_RXEN | C_SEQ);
        pkt(1'b1, 1'b1, W'(1));
        cycles(3);
        check("R11 R13 all stamps seen", W'(expq.size()), '0);

        // R2 disable returns to held
        wr(2'd0, C_POL);
        cycles(2);
        check("R2 disable clears", time_now, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule